// File: doc/BRIEF.md
# TDM Time-Slot Interchange Core

This core moves byte-wide channel samples between the time-slots of a framed time-division stream. Each clock cycle is one time-slot. The byte that arrives in a slot is stored in a data store, indexed by the slot number. For each outgoing slot, a connection map names the incoming slot whose byte is sent there. A frame holds SLOTS time-slots: 32, 64 or 128 for the 2.048, 4.096 and 8.192 Mb/s line rates.

A mode input picks one of two latency policies. In variable-delay mode a sample leaves at the first matching output slot that the three-stage read pipeline can reach. This can be in the same frame or in the next one. In constant-delay mode the core stores frames in three rotating banks. Every byte received in frame k leaves in frame k+2, so the whole frame stays aligned whatever the map. The map has a shadow copy that can be written at any time. The shadow is moved into the active copy once per frame, so an output frame never mixes two maps.

Top module: `tdm_tsi_core`

## Requirements
- R1: `slot_num` is 0 in any cycle where `frame_start` is 1. Otherwise it is one more than its value in the previous cycle, and it wraps from SLOTS-1 to 0. After reset the count starts at 0.
- R2: While `rst` is held, `tx_data` is 0 and `slot_num` is 0.
- R3: With constant mode latched (`const_mode`=1), output slot m of frame k carries the byte received in slot n of frame k-2, where n is the map entry for m. The latency is therefore 2*SLOTS + m - n cycles, which ranges from SLOTS+1 to 3*SLOTS-1.
- R4: With variable mode latched (`const_mode`=0) and m >= n+3, the byte received in slot n leaves in slot m of the same frame, m - n cycles later.
- R5: With variable mode latched and m <= n+2, the latency is ((m - n - 3) mod SLOTS) + 3 cycles. This is SLOTS + m - n in general. It is 2*SLOTS + m - n only for the pairs that wrap past the frame edge.
- R6: A write with `map_wr_en`=1 stores `map_wr_src` as the input slot for output slot `map_wr_slot` in the shadow map. At the end of the slot SLOTS-4 cycle the shadow map is copied into the active map, and the copy governs output slots 0 to SLOTS-1 of the next frame. A shadow write never changes the current output frame.
- R7: `const_mode` is sampled only in slot 0 of each frame. A change at any other slot takes effect from the next slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one cycle per time-slot |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Marks the cycle of slot 0 |
| const_mode | input | 1 | 1 selects constant delay, 0 selects variable delay; sampled in slot 0 |
| rx_data | input | DW (8) | Incoming channel byte for the current slot |
| map_wr_en | input | 1 | Shadow map write strobe |
| map_wr_slot | input | log2(SLOTS) (5) | Output slot whose map entry is written |
| map_wr_src | input | log2(SLOTS) (5) | Input slot to be switched to that output slot |
| slot_num | output | log2(SLOTS) (5) | Current time-slot number |
| tx_data | output | DW (8) | Outgoing channel byte for the current slot |

## Verification
`slot_num` follows `frame_start` in the same cycle. `tx_data` for a slot is registered and reflects a store read made two cycles earlier, so the bench drives each slot's inputs at the falling edge and reads both outputs one step later, within that same slot. For every output cycle the bench computes the expected source cycle from the R3 to R5 latency formulas, the map snapshot it took at slot SLOTS-4 of the previous frame, and the mode it recorded at slot 0. It checks only frames whose mode was stable for the two frames before, and skips sources that fall before the first slot. A sweep of 32 rotated maps in each mode covers every (n, m) pair at SLOTS=32.

// File: rtl/tdm_tsi_pkg.sv
package tdm_tsi_pkg;

    typedef enum logic {
        MODE_VARIABLE = 1'b0,
        MODE_CONSTANT = 1'b1
    } tsi_mode_e;

    // Frame banks used by the constant-delay path: write, hold, read.
    localparam int unsigned NUM_BANKS = 3;

    // Slots between the map lookup and the slot whose byte it selects.
    localparam int unsigned PIPE_LEAD = 3;

    typedef logic [1:0] bank_t;

    typedef struct packed {
        logic      frame_begin;
        logic      map_load;
        tsi_mode_e mode;
        bank_t     wr_bank;
        bank_t     rd_bank;
    } tsi_ctl_t;

    // Modulo-3 step of a bank index by 0..2 positions.
    function automatic bank_t bank_advance(input bank_t b, input int unsigned by);
        int unsigned s;
        s = 32'(b) + by;
        if (s >= NUM_BANKS) s = s - NUM_BANKS;
        if (s >= NUM_BANKS) s = s - NUM_BANKS;
        return bank_t'(s);
    endfunction

endpackage

// File: rtl/tsi_slot_timer.sv
module tsi_slot_timer
    import tdm_tsi_pkg::*;
#(
    parameter int unsigned SLOTS = 32,
    parameter int unsigned SW    = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_start,
    input  logic          const_mode,
    output logic [SW-1:0] slot,
    output tsi_ctl_t      ctl
);

    localparam logic [SW-1:0] LAST     = SW'(SLOTS - 1);
    localparam logic [SW-1:0] LOAD_AT  = SW'(SLOTS - 4);
    localparam logic [SW-1:0] NEAR_END = SW'(SLOTS - 2);

    logic [SW-1:0] slot_q;
    logic [SW-1:0] cur;
    logic          begin_f;
    tsi_mode_e     mode_q, mode_cur;
    bank_t         rot_q, rot_cur;

    always_comb begin
        cur      = frame_start ? '0 : slot_q;
        begin_f  = (cur == '0);
        mode_cur = begin_f ? (const_mode ? MODE_CONSTANT : MODE_VARIABLE) : mode_q;
        rot_cur  = begin_f ? bank_advance(rot_q, 1) : rot_q;

        ctl.frame_begin = begin_f;
        ctl.map_load    = (cur == LOAD_AT);
        ctl.mode        = mode_cur;
        if (mode_cur == MODE_CONSTANT) begin
            ctl.wr_bank = rot_cur;
            // The read in this cycle feeds output slot cur+2; near the
            // frame end that slot belongs to the next frame.
            ctl.rd_bank = (cur >= NEAR_END) ? bank_advance(rot_cur, 2)
                                            : bank_advance(rot_cur, 1);
        end else begin
            ctl.wr_bank = '0;
            ctl.rd_bank = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
            mode_q <= MODE_VARIABLE;
            rot_q  <= '0;
        end else begin
            slot_q <= (cur == LAST) ? '0 : cur + 1'b1;
            mode_q <= mode_cur;
            rot_q  <= rot_cur;
        end
    end

    assign slot = cur;

    // R1: the slot number steps by one unless a frame start re-aligns it
    a_r1_slot_step: assert property (@(posedge clk) disable iff (rst)
        (slot != LAST) |=> (frame_start || slot == SW'($past(slot) + 1'b1)));

    // R1: the last slot of a frame is always followed by slot 0
    a_r1_slot_wrap: assert property (@(posedge clk) disable iff (rst)
        (slot == LAST) |=> (slot == '0));

    // R7: the latched mode only changes in a slot-0 cycle
    a_r7_mode_hold: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ctl.frame_begin || ctl.mode == $past(ctl.mode)));

    // R3: in constant mode the bank being filled is never the one being read
    a_r3_bank_apart: assert property (@(posedge clk) disable iff (rst)
        (ctl.mode == MODE_CONSTANT) |-> (ctl.wr_bank != ctl.rd_bank));

endmodule

// File: rtl/tsi_conn_map.sv
module tsi_conn_map #(
    parameter int unsigned SLOTS = 32,
    parameter int unsigned SW    = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_slot,
    input  logic [SW-1:0] wr_src,
    input  logic          load,
    input  logic [SW-1:0] look_slot,
    output logic [SW-1:0] look_src
);

    logic [SLOTS-1:0][SW-1:0] shadow_q;
    logic [SLOTS-1:0][SW-1:0] active_q;
    logic [SW-1:0]            look_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            active_q <= '0;
            look_q   <= '0;
        end else begin
            for (int i = 0; i < int'(SLOTS); i++) begin
                if (wr_en && wr_slot == SW'(i)) shadow_q[i] <= wr_src;
                if (load) active_q[i] <= shadow_q[i];
            end
            look_q <= active_q[look_slot];
        end
    end

    assign look_src = look_q;

    // R6: the active map changes only on the once-per-frame load
    a_r6_map_hold: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(active_q));

endmodule

// File: rtl/tsi_frame_store.sv
module tsi_frame_store
    import tdm_tsi_pkg::*;
#(
    parameter int unsigned SLOTS = 32,
    parameter int unsigned SW    = $clog2(SLOTS),
    parameter int unsigned DW    = 8
) (
    input  logic          clk,
    input  bank_t         wr_bank,
    input  logic [SW-1:0] wr_slot,
    input  logic [DW-1:0] wr_data,
    input  bank_t         rd_bank,
    input  logic [SW-1:0] rd_slot,
    output logic [DW-1:0] rd_data
);

    logic [NUM_BANKS-1:0][DW-1:0] bank_out;
    logic [DW-1:0]                rd_q;

    for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_bank
        logic [DW-1:0] cells [SLOTS];

        always_ff @(posedge clk) begin
            if (wr_bank == bank_t'(b)) cells[wr_slot] <= wr_data;
        end

        assign bank_out[b] = cells[rd_slot];
    end

    always_ff @(posedge clk) begin
        rd_q <= '0;
        for (int b = 0; b < int'(NUM_BANKS); b++) begin
            if (rd_bank == bank_t'(b)) rd_q <= bank_out[b];
        end
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/tdm_tsi_core.sv
module tdm_tsi_core
    import tdm_tsi_pkg::*;
#(
    parameter int unsigned SLOTS = 32,
    parameter int unsigned DW    = 8,
    parameter int unsigned SW    = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_start,
    input  logic          const_mode,
    input  logic [DW-1:0] rx_data,
    input  logic          map_wr_en,
    input  logic [SW-1:0] map_wr_slot,
    input  logic [SW-1:0] map_wr_src,
    output logic [SW-1:0] slot_num,
    output logic [DW-1:0] tx_data
);

    localparam logic [SW:0] LEAD_W  = (SW+1)'(PIPE_LEAD);
    localparam logic [SW:0] SLOTS_W = (SW+1)'(SLOTS);

    tsi_ctl_t      ctl;
    logic [SW:0]   look_sum;
    logic [SW-1:0] look_slot;
    logic [SW-1:0] src_slot;
    logic [DW-1:0] rd_data;
    logic [DW-1:0] tx_q;

    tsi_slot_timer #(.SLOTS(SLOTS), .SW(SW)) u_timer (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .const_mode  (const_mode),
        .slot        (slot_num),
        .ctl         (ctl)
    );

    // Look up the map PIPE_LEAD slots ahead of the slot being emitted.
    always_comb begin
        look_sum  = {1'b0, slot_num} + LEAD_W;
        look_slot = (look_sum >= SLOTS_W) ? SW'(look_sum - SLOTS_W) : SW'(look_sum);
    end

    tsi_conn_map #(.SLOTS(SLOTS), .SW(SW)) u_map (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (map_wr_en),
        .wr_slot   (map_wr_slot),
        .wr_src    (map_wr_src),
        .load      (ctl.map_load),
        .look_slot (look_slot),
        .look_src  (src_slot)
    );

    tsi_frame_store #(.SLOTS(SLOTS), .SW(SW), .DW(DW)) u_store (
        .clk     (clk),
        .wr_bank (ctl.wr_bank),
        .wr_slot (slot_num),
        .wr_data (rx_data),
        .rd_bank (ctl.rd_bank),
        .rd_slot (src_slot),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) tx_q <= '0;
        else     tx_q <= rd_data;
    end

    assign tx_data = tx_q;

    // R1: a frame-start cycle always carries slot number 0
    a_r1_frame_align: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (slot_num == '0 && ctl.frame_begin));

endmodule

// File: tb/test_tdm_tsi_core.sv
module test_tdm_tsi_core;

    localparam int F          = 32;
    localparam int SW         = 5;
    localparam int LAST_FRAME = 252;
    localparam int NCYC       = (LAST_FRAME + 1) * F;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          frame_start = 1'b0;
    logic          const_mode = 1'b0;
    logic [7:0]    rx_data = '0;
    logic          map_wr_en = 1'b0;
    logic [SW-1:0] map_wr_slot = '0;
    logic [SW-1:0] map_wr_src = '0;
    logic [SW-1:0] slot_num;
    logic [7:0]    tx_data;

    always #10 clk = ~clk;

    tdm_tsi_core #(.SLOTS(F), .DW(8)) i_tdm_tsi_core (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .const_mode  (const_mode),
        .rx_data     (rx_data),
        .map_wr_en   (map_wr_en),
        .map_wr_slot (map_wr_slot),
        .map_wr_src  (map_wr_src),
        .slot_num    (slot_num),
        .tx_data     (tx_data)
    );

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    logic [7:0]    hist     [0:16383];
    bit            mode_hist[0:511];
    logic [SW-1:0] map_hist [0:511][0:F-1];
    logic [SW-1:0] shadow_m [0:F-1];

    task automatic report(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int var_delay(input int m, input int n);
        return ((m - n - 3 + 2 * F) % F) + 3;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 200000, NCYC);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int  exp_slot;
        bit  cur_mode;
        void'($urandom(32'd20240));
        for (int f = 0; f < 512; f++) begin
            mode_hist[f] = 1'b0;
            for (int j = 0; j < F; j++) map_hist[f][j] = '0;
        end
        for (int j = 0; j < F; j++) shadow_m[j] = '0;
        exp_slot = 0;
        cur_mode = 1'b0;

        // R2: state held in reset
        repeat (3) @(negedge clk);
        #1;
        report(tx_data == 8'd0, "R2 tx_data in reset", int'(tx_data), 0);
        report(slot_num == '0, "R2 slot_num in reset", int'(slot_num), 0);

        for (int t = 0; t < NCYC; t++) begin
            int  k, s, sh;
            bit  fs, we;
            logic [SW-1:0] ws, wsrc;
            logic [7:0]    rx;
            @(negedge clk);
            k  = t / F;
            s  = t % F;
            rx = 8'($urandom);
            hist[t] = rx;
            fs = (s == 0) || (k == LAST_FRAME && s == 10);
            we = 1'b0;
            ws = '0;
            wsrc = '0;
            if (k < 192) begin
                // map sweep: shift sh written in the first of every three frames
                cur_mode = (k < 96);
                sh = (k % 96) / 3;
                if (k % 3 == 0) begin
                    we   = 1'b1;
                    ws   = SW'(s);
                    wsrc = SW'((s + sh) % F);
                end
            end else if (k < LAST_FRAME) begin
                if ($urandom % 150 == 0) cur_mode = ~cur_mode;
                if ($urandom % 4 == 0) begin
                    we   = 1'b1;
                    ws   = SW'($urandom % F);
                    wsrc = SW'($urandom % F);
                end
            end
            rst         = 1'b0;
            frame_start = fs;
            const_mode  = cur_mode;
            rx_data     = rx;
            map_wr_en   = we;
            map_wr_slot = ws;
            map_wr_src  = wsrc;
            if (s == 0) mode_hist[k] = cur_mode;
            exp_slot = fs ? 0 : (exp_slot + 1) % F;
            #1;

            // R1: slot counter, including the mid-frame re-alignment at the end
            report(slot_num == SW'(exp_slot), "R1 slot_num", int'(slot_num), exp_slot);

            if (k >= 2 && k < LAST_FRAME &&
                mode_hist[k - 1] == mode_hist[k] && mode_hist[k - 2] == mode_hist[k]) begin
                int m, n, d;
                string tag;
                m = s;
                n = int'(map_hist[k][m]);
                d = mode_hist[k] ? (2 * F + m - n) : var_delay(m, n);
                if (t - d >= 0) begin
                    if (mode_hist[k])  tag = "R3 constant latency";
                    else if (m >= n + 3) tag = "R4 variable same-frame latency";
                    else                 tag = "R5 variable next-frame latency";
                    if (shadow_m[m] != map_hist[k][m]) tag = "R6 pending map entry not yet applied";
                    if (cur_mode != mode_hist[k])      tag = "R7 mode change held to next frame";
                    report(tx_data == hist[t - d], tag, int'(tx_data), int'(hist[t - d]));
                end
            end

            if (s == F - 4) begin
                for (int j = 0; j < F; j++) map_hist[k + 1][j] = shadow_m[j];
            end
            if (we) shadow_m[ws] = wsrc;
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule